// File: doc/BRIEF.md
# Set-Associative Data Cache Line Controller

This block is a small data-cache controller placed between a CPU port that issues one word per request and a memory port that moves whole lines. Every line is eight words long and carries a tag, a single valid bit and a pair of dirty bits. Dirty bit 0 covers words 0 to 3 and dirty bit 1 covers words 4 to 7. A lookup compares the request tag against every way of the indexed set. On a miss the controller picks a victim way, writes back only the modified halves of that victim, refills the line from word 0 upward, and only then completes the request.

Each store chooses its update policy with its own request bit. A write-through store sends the word straight to memory and never allocates a line. A write-back store allocates on a miss: it fetches the line, merges the store into it and marks the matching half dirty. Victim choice can be switched at run time between a per-set round-robin counter and a free-running pseudo-random generator. A one-cycle invalidate input discards the whole contents without any write-back. The tag, state and data arrays are built from registers, and set count, way count, line length and widths are parameters, so a scaled-down geometry can be exercised.

Top module: `cache_ctrl`

## Requirements
- R1: After reset, cpu_ready is 1, cpu_done, mem_rd_req and mem_wr_valid are 0, and every line is invalid, so the first read of any address misses.
- R2: A read that hits returns the addressed word on cpu_rdata with cpu_done one clock after the clock that accepted the request, and causes no memory traffic.
- R3: A read miss to a clean or invalid victim raises mem_rd_req for exactly one cycle, with mem_rd_addr set to the line base (the low three offset bits are zero). The controller then takes eight beats on mem_rd_valid, in order from word 0. cpu_done is raised in the cycle after the eighth beat is taken, and cpu_rdata then holds the requested word.
- R4: A write-through store (cpu_we=1, cpu_wt=1) produces exactly one mem_wr_valid beat carrying the request address and data, registered on the same clock as cpu_done. On a hit it also updates the cached word without marking it dirty.
- R5: A write-through store that misses does not allocate a line and issues no read request, so a later read of that address misses and returns the stored value from memory.
- R6: A write-back store (cpu_we=1, cpu_wt=0) that hits updates the cached word, completes with the hit latency of R2, and causes no memory traffic.
- R7: A write-back store that misses fetches the line as in R3, merges the store data into it, completes after the refill, and writes nothing to memory itself. A later read of the address hits and returns the stored data.
- R8: Dirty bit 0 covers words 0-3 and dirty bit 1 covers words 4-7. On eviction, each dirty half is written back as a burst of four consecutive words, lower half first, and the burst ends before mem_rd_req rises. A victim with no dirty half is not written back.
- R9: The victim is the lowest-numbered invalid way of the set. When the set is full, cfg_rand=0 selects the set's round-robin counter, which is 0 after reset and advances by one after every fill of that set. cfg_rand=1 selects the low bits of a pseudo-random generator that advances every clock.
- R10: When inv_all is 1 while cpu_ready is 1, every valid and dirty bit is cleared in that clock with no write-back, and a cpu_req in the same cycle is ignored.
- R11: cpu_ready falls in the cycle after a request is accepted and returns together with cpu_done. cpu_done is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rand | input | 1 | Victim policy: 0 round-robin, 1 pseudo-random |
| inv_all | input | 1 | Invalidate every line, discarding dirty data |
| cpu_req | input | 1 | Request strobe, taken while cpu_ready is 1 |
| cpu_we | input | 1 | 1 store, 0 load |
| cpu_wt | input | 1 | Store policy: 1 write-through, 0 write-back |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Controller idle, request may be issued |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_done |
| mem_rd_req | output | 1 | One-cycle line refill request |
| mem_rd_addr | output | ADDR_W | Line base word address of the refill |
| mem_rd_valid | input | 1 | Refill beat valid |
| mem_rd_data | input | DATA_W | Refill beat data |
| mem_wr_valid | output | 1 | Memory write beat (always accepted) |
| mem_wr_addr | output | ADDR_W | Word address of the write beat |
| mem_wr_data | output | DATA_W | Data of the write beat |

## Verification
Each result has a fixed latency, counted in falling edges after the edge at which the request is driven. A hit or a write-through store shows cpu_done at the second falling edge, a clean miss at the eleventh, a miss with one dirty half at the fifteenth and a miss with both halves dirty at the nineteenth. The bench measures that count for every request and compares it with the count expected from the line state it has built up, so an unnecessary write-back, a missing write-back or an early completion each shows up as a latency error. Memory write beats are captured on the rising edge after they appear and checked one cycle after completion. That capture gives the address order of every burst and the memory contents that each policy leaves behind.

// File: rtl/cache_pkg.sv
`timescale 1ns/1ps
package cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOOK  = 3'd1,
    ST_WB    = 3'd2,
    ST_FREQ  = 3'd3,
    ST_FILL  = 3'd4
  } cst_e;

  // 16-bit Galois LFSR, maximal length
  localparam logic [15:0] LFSR_TAPS = 16'hB400;
  localparam logic [15:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/cache_tags.sv
`timescale 1ns/1ps
module cache_tags #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 11,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int ENT   = SETS * WAYS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inv,
  input  logic [IDX_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic [WAY_W-1:0] sel_way,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic [WAYS-1:0]  set_valid,
  output logic [1:0]       sel_dirty,
  output logic [TAG_W-1:0] sel_tag,
  input  logic             fill_en,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [1:0]       fill_dirty,
  input  logic             mark_en,
  input  logic [WAY_W-1:0] mark_way,
  input  logic             mark_half,
  output logic [ENT-1:0]   valid_all
);
  logic [TAG_W-1:0]    tag_q [ENT];
  logic [ENT-1:0]      val_q;
  logic [ENT-1:0][1:0] dty_q;
  logic [WAYS-1:0]     match;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    localparam logic [WAY_W-1:0] WI = WAY_W'(w);
    assign set_valid[w] = val_q[{lk_set, WI}];
    assign match[w]     = set_valid[w] && (tag_q[{lk_set, WI}] == lk_tag);
  end

  assign hit = |match;

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (match[i]) hit_way = WAY_W'(i);
    end
  end

  assign sel_dirty = dty_q[{lk_set, sel_way}];
  assign sel_tag   = tag_q[{lk_set, sel_way}];
  assign valid_all = val_q;

  always_ff @(posedge clk) begin
    if (rst || inv) begin
      val_q <= '0;
      dty_q <= '0;
    end else begin
      if (fill_en) begin
        val_q[{lk_set, fill_way}] <= 1'b1;
        dty_q[{lk_set, fill_way}] <= fill_dirty;
      end
      if (mark_en) dty_q[{lk_set, mark_way}][mark_half] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[{lk_set, fill_way}] <= lk_tag;
  end
endmodule

// File: rtl/cache_victim.sv
`timescale 1ns/1ps
module cache_victim #(
  parameter int SETS = 4,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_rand,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [WAYS-1:0]  set_valid,
  input  logic             adv_en,
  output logic [WAY_W-1:0] vic_way
);
  import cache_pkg::*;

  logic [15:0]      lfsr_q;
  logic [WAY_W-1:0] rr_q [SETS];
  logic             free_any;
  logic [WAY_W-1:0] free_way;

  always_ff @(posedge clk) begin
    if (rst) lfsr_q <= LFSR_SEED;
    else     lfsr_q <= {1'b0, lfsr_q[15:1]} ^ (lfsr_q[0] ? LFSR_TAPS : 16'h0000);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (adv_en) begin
      rr_q[set_idx] <= rr_q[set_idx] + 1'b1;
    end
  end

  always_comb begin
    free_any = 1'b0;
    free_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!set_valid[i]) begin
        free_any = 1'b1;
        free_way = WAY_W'(i);
      end
    end
  end

  assign vic_way = free_any ? free_way
                 : (cfg_rand ? lfsr_q[WAY_W-1:0] : rr_q[set_idx]);
endmodule

// File: rtl/cache_data.sv
`timescale 1ns/1ps
module cache_data #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/cache_ctrl.sv
`timescale 1ns/1ps
module cache_ctrl #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int SETS       = 4,
  parameter int WAYS       = 4,
  parameter int LINE_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_rand,
  input  logic              inv_all,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_wt,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data
);
  import cache_pkg::*;

  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int DEPTH = SETS * WAYS * LINE_WORDS;
  localparam int DAW   = $clog2(DEPTH);
  localparam logic [OFF_W-1:0] OFF_LAST  = OFF_W'(LINE_WORDS - 1);
  localparam logic [OFF_W-1:0] HALF_LAST = OFF_W'(LINE_WORDS / 2 - 1);
  localparam logic [OFF_W-1:0] HALF_BASE = OFF_W'(LINE_WORDS / 2);

  cst_e             st_q;
  logic             rq_we, rq_wt;
  logic [TAG_W-1:0] rq_tag;
  logic [IDX_W-1:0] rq_set;
  logic [OFF_W-1:0] rq_off;
  logic [DATA_W-1:0] rq_wdata;
  logic [WAY_W-1:0] vic_q;
  logic [TAG_W-1:0] vic_tag_q;
  logic [1:0]       vic_dty_q;
  logic [OFF_W-1:0] ptr_q;

  logic             hit;
  logic [WAY_W-1:0] hit_way, vic_way;
  logic [WAYS-1:0]  set_valid;
  logic [1:0]       sel_dirty;
  logic [TAG_W-1:0] sel_tag;
  logic             fill_en, mark_en, tag_inv;
  logic [1:0]       fill_dirty;
  logic [SETS*WAYS-1:0] tag_valid_all;

  logic             dwe;
  logic [DAW-1:0]   dwaddr, draddr;
  logic [DATA_W-1:0] dwdata, drdata;
  logic             beat_last, wb_last;

  assign cpu_ready = (st_q == ST_IDLE);
  assign tag_inv   = inv_all && (st_q == ST_IDLE);
  assign beat_last = (ptr_q == OFF_LAST);
  assign wb_last   = beat_last || ((ptr_q == HALF_LAST) && !vic_dty_q[1]);
  assign fill_en   = (st_q == ST_FILL) && mem_rd_valid && beat_last;
  assign fill_dirty = rq_we ? (rq_off[OFF_W-1] ? 2'b10 : 2'b01) : 2'b00;
  assign mark_en   = (st_q == ST_LOOK) && rq_we && !rq_wt && hit;

  cache_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .inv(tag_inv),
    .lk_set(rq_set), .lk_tag(rq_tag), .sel_way(vic_way),
    .hit(hit), .hit_way(hit_way), .set_valid(set_valid),
    .sel_dirty(sel_dirty), .sel_tag(sel_tag),
    .fill_en(fill_en), .fill_way(vic_q), .fill_dirty(fill_dirty),
    .mark_en(mark_en), .mark_way(hit_way), .mark_half(rq_off[OFF_W-1]),
    .valid_all(tag_valid_all)
  );

  cache_victim #(.SETS(SETS), .WAYS(WAYS)) u_vic (
    .clk(clk), .rst(rst), .cfg_rand(cfg_rand), .set_idx(rq_set),
    .set_valid(set_valid), .adv_en(fill_en), .vic_way(vic_way)
  );

  cache_data #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_data (
    .clk(clk), .we(dwe), .waddr(dwaddr), .wdata(dwdata),
    .raddr(draddr), .rdata(drdata)
  );

  assign draddr = (st_q == ST_WB) ? {rq_set, vic_q, ptr_q} : {rq_set, hit_way, rq_off};

  always_comb begin
    dwe    = 1'b0;
    dwaddr = {rq_set, hit_way, rq_off};
    dwdata = rq_wdata;
    if (st_q == ST_LOOK && rq_we && hit) dwe = 1'b1;
    if (st_q == ST_FILL && mem_rd_valid) begin
      dwe    = 1'b1;
      dwaddr = {rq_set, vic_q, ptr_q};
      dwdata = (rq_we && ptr_q == rq_off) ? rq_wdata : mem_rd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
      cpu_done <= 1'b0; cpu_rdata <= '0;
      mem_rd_req <= 1'b0; mem_rd_addr <= '0;
      mem_wr_valid <= 1'b0; mem_wr_addr <= '0; mem_wr_data <= '0;
      rq_we <= 1'b0; rq_wt <= 1'b0; rq_tag <= '0; rq_set <= '0; rq_off <= '0;
      rq_wdata <= '0; vic_q <= '0; vic_tag_q <= '0; vic_dty_q <= '0; ptr_q <= '0;
    end else begin
      cpu_done     <= 1'b0;
      mem_rd_req   <= 1'b0;
      mem_wr_valid <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (!inv_all && cpu_req) begin
            rq_we    <= cpu_we;
            rq_wt    <= cpu_wt;
            rq_tag   <= cpu_addr[ADDR_W-1 -: TAG_W];
            rq_set   <= cpu_addr[OFF_W +: IDX_W];
            rq_off   <= cpu_addr[OFF_W-1:0];
            rq_wdata <= cpu_wdata;
            st_q     <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (rq_we && rq_wt) begin
            mem_wr_valid <= 1'b1;
            mem_wr_addr  <= {rq_tag, rq_set, rq_off};
            mem_wr_data  <= rq_wdata;
            cpu_done     <= 1'b1;
            st_q         <= ST_IDLE;
          end else if (hit) begin
            if (!rq_we) cpu_rdata <= drdata;
            cpu_done <= 1'b1;
            st_q     <= ST_IDLE;
          end else begin
            vic_q     <= vic_way;
            vic_tag_q <= sel_tag;
            vic_dty_q <= sel_dirty;
            if (|sel_dirty) begin
              ptr_q <= sel_dirty[0] ? '0 : HALF_BASE;
              st_q  <= ST_WB;
            end else begin
              st_q  <= ST_FREQ;
            end
          end
        end
        ST_WB: begin
          mem_wr_valid <= 1'b1;
          mem_wr_addr  <= {vic_tag_q, rq_set, ptr_q};
          mem_wr_data  <= drdata;
          if (wb_last) st_q <= ST_FREQ;
          else         ptr_q <= ptr_q + 1'b1;
        end
        ST_FREQ: begin
          mem_rd_req  <= 1'b1;
          mem_rd_addr <= {rq_tag, rq_set, {OFF_W{1'b0}}};
          ptr_q       <= '0;
          st_q        <= ST_FILL;
        end
        ST_FILL: begin
          if (mem_rd_valid) begin
            if (!rq_we && ptr_q == rq_off) cpu_rdata <= mem_rd_data;
            if (beat_last) begin
              cpu_done <= 1'b1;
              st_q     <= ST_IDLE;
            end else begin
              ptr_q <= ptr_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cache_ctrl_chk.sv
`timescale 1ns/1ps
module cache_ctrl_chk #(
  parameter int ENT = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           cpu_req,
  input logic           cpu_ready,
  input logic           cpu_done,
  input logic           inv_all,
  input logic           mem_rd_req,
  input logic           mem_wr_valid,
  input logic [ENT-1:0] valid_all
);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);

  // R11
  done_when_ready_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> cpu_ready);

  // R11
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_ready && !inv_all) |=> !cpu_ready);

  // R3
  rd_req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |=> !mem_rd_req);

  // R8
  wb_before_refill_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> !mem_wr_valid);

  // R10
  inv_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (inv_all && cpu_ready) |=> (valid_all == '0));

  // R10
  inv_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (inv_all && cpu_ready) |=> (!mem_wr_valid && cpu_ready));
endmodule

bind cache_ctrl cache_ctrl_chk #(.ENT(SETS * WAYS)) u_chk (
  .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
  .cpu_done(cpu_done), .inv_all(inv_all), .mem_rd_req(mem_rd_req),
  .mem_wr_valid(mem_wr_valid), .valid_all(tag_valid_all)
);

// File: tb/sim_cache_ctrl.sv
`timescale 1ns/1ps
module sim_cache_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_rand = 1'b0, inv_all = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_wt = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready, cpu_done;
  logic [31:0] cpu_rdata;
  logic        mem_rd_req;
  logic [15:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        mem_wr_valid;
  logic [15:0] mem_wr_addr;
  logic [31:0] mem_wr_data;

  int n_chk = 0, n_bad = 0;
  int rd_cnt = 0;
  int last_rd_addr = 0;
  int wcnt;
  int wlog [64];
  logic [31:0] mem_m [1024];
  logic [31:0] rd;
  int lat;
  logic rdy_after;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cache_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_rand(cfg_rand), .inv_all(inv_all),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_wt(cpu_wt),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data)
  );

  function automatic logic [31:0] mval(int a);
    return 32'h5A00_0000 + 32'(a * 7);
  endfunction

  function automatic logic [31:0] dv(int k);
    return 32'hC0DE_0000 + 32'(k);
  endfunction

  // memory writes: captured on the edge after the beat appears
  initial begin
    wcnt = 0;
    for (int i = 0; i < 1024; i++) mem_m[i] <= mval(i);
  end

  always @(posedge clk) begin
    if (!rst && mem_wr_valid) begin
      mem_m[mem_wr_addr[9:0]] <= mem_wr_data;
      if (wcnt < 64) wlog[wcnt] <= int'(mem_wr_addr);
      wcnt <= wcnt + 1;
    end
  end

  // refill responder: 8 beats starting on the falling edge that sees the request
  always begin
    @(negedge clk);
    if (!rst && mem_rd_req) begin
      rd_cnt++;
      last_rd_addr = int'(mem_rd_addr);
      for (int b = 0; b < 8; b++) begin
        mem_rd_valid = 1'b1;
        mem_rd_data  = mem_m[10'(last_rd_addr + b)];
        @(negedge clk);
      end
      mem_rd_valid = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic we, input logic wt, input int addr, input logic [31:0] wd);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_wt = wt;
    cpu_addr = 16'(addr); cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    rdy_after = cpu_ready;
    lat = 1;
    while (!cpu_done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    rd = cpu_rdata;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(cpu_ready == 1'b1, "R1 ready", 32'(cpu_ready), 1);
    chk(cpu_done == 1'b0, "R1 done", 32'(cpu_done), 0);
    chk(mem_rd_req == 1'b0, "R1 rd_req", 32'(mem_rd_req), 0);
    chk(mem_wr_valid == 1'b0, "R1 wr_valid", 32'(mem_wr_valid), 0);
  endtask

  task automatic t_read_miss;
    int r0, w0;
    r0 = rd_cnt; w0 = wcnt;
    op(1'b0, 1'b0, 37, '0);
    chk(rdy_after == 1'b0, "R11 ready low after accept", 32'(rdy_after), 0);
    chk(lat == 11, "R3 miss latency", 32'(lat), 11);
    chk(rd_cnt == r0 + 1, "R1 first read misses", 32'(rd_cnt - r0), 1);
    chk(last_rd_addr == 32, "R3 line base address", 32'(last_rd_addr), 32);
    chk(rd == mval(37), "R3 miss data", rd, mval(37));
    chk(wcnt == w0, "R8 clean victim no write-back", 32'(wcnt - w0), 0);
  endtask

  task automatic t_read_hit;
    int r0;
    r0 = rd_cnt;
    op(1'b0, 1'b0, 34, '0);
    chk(lat == 2, "R2 hit latency", 32'(lat), 2);
    chk(rd == mval(34), "R2 hit data", rd, mval(34));
    chk(rd_cnt == r0, "R2 no refill on hit", 32'(rd_cnt - r0), 0);
  endtask

  task automatic t_wt_hit;
    int w0;
    w0 = wcnt;
    op(1'b1, 1'b1, 35, dv(1));
    chk(lat == 2, "R4 write-through latency", 32'(lat), 2);
    chk(wcnt == w0 + 1, "R4 one write beat", 32'(wcnt - w0), 1);
    chk(wlog[w0] == 35, "R4 write address", 32'(wlog[w0]), 35);
    chk(mem_m[35] == dv(1), "R4 memory updated", mem_m[35], dv(1));
    op(1'b0, 1'b0, 35, '0);
    chk(lat == 2 && rd == dv(1), "R4 cached copy updated", rd, dv(1));
  endtask

  task automatic t_wt_miss;
    int r0, w0;
    r0 = rd_cnt; w0 = wcnt;
    op(1'b1, 1'b1, 64, dv(2));
    chk(lat == 2, "R5 write-through miss latency", 32'(lat), 2);
    chk(rd_cnt == r0, "R5 no refill on write-through miss", 32'(rd_cnt - r0), 0);
    chk(wcnt == w0 + 1 && wlog[w0] == 64, "R5 write beat address", 32'(wlog[w0]), 64);
    op(1'b0, 1'b0, 64, '0);
    chk(lat == 11, "R5 line not allocated", 32'(lat), 11);
    chk(rd == dv(2), "R5 data from memory", rd, dv(2));
  endtask

  task automatic t_wb_store;
    int r0, w0;
    r0 = rd_cnt; w0 = wcnt;
    op(1'b1, 1'b0, 102, dv(3));
    chk(lat == 11, "R7 allocate latency", 32'(lat), 11);
    chk(rd_cnt == r0 + 1, "R7 refill issued", 32'(rd_cnt - r0), 1);
    chk(wcnt == w0, "R7 no memory write", 32'(wcnt - w0), 0);
    chk(mem_m[102] == mval(102), "R7 memory untouched", mem_m[102], mval(102));
    op(1'b0, 1'b0, 102, '0);
    chk(lat == 2 && rd == dv(3), "R7 merged store", rd, dv(3));
    op(1'b0, 1'b0, 100, '0);
    chk(rd == mval(100), "R7 rest of line from memory", rd, mval(100));
    op(1'b1, 1'b0, 101, dv(4));
    chk(lat == 2, "R6 write-back hit latency", 32'(lat), 2);
    chk(wcnt == w0 && rd_cnt == r0 + 1, "R6 no memory traffic", 32'(wcnt - w0), 0);
    op(1'b0, 1'b0, 101, '0);
    chk(rd == dv(4), "R6 hit data updated", rd, dv(4));
  endtask

  task automatic t_round_robin;
    int w0;
    cfg_rand = 1'b0;
    op(1'b1, 1'b0, 57,  dv(10));
    op(1'b1, 1'b0, 93,  dv(11));
    op(1'b1, 1'b0, 122, dv(12));
    op(1'b1, 1'b0, 158, dv(13));
    chk(lat == 11, "R7 fill of full-set build", 32'(lat), 11);
    op(1'b1, 1'b0, 126, dv(14));
    chk(lat == 2, "R6 hit marks upper half", 32'(lat), 2);
    // first victim: way 0 (line at 56), lower half dirty
    w0 = wcnt;
    op(1'b0, 1'b0, 184, '0);
    chk(lat == 15, "R8 one-half write-back latency", 32'(lat), 15);
    chk(wcnt == w0 + 4, "R8 four-word burst", 32'(wcnt - w0), 4);
    for (int i = 0; i < 4; i++)
      chk(wlog[w0 + i] == 56 + i, "R9 round-robin victim way 0", 32'(wlog[w0 + i]), 32'(56 + i));
    chk(mem_m[57] == dv(10), "R8 dirty word written back", mem_m[57], dv(10));
    chk(rd == mval(184), "R3 data after eviction", rd, mval(184));
    // second victim: way 1 (line at 88), upper half dirty only
    w0 = wcnt;
    op(1'b0, 1'b0, 216, '0);
    chk(lat == 15 && wcnt == w0 + 4, "R8 upper half only", 32'(wcnt - w0), 4);
    chk(wlog[w0] == 92, "R9 round-robin victim way 1", 32'(wlog[w0]), 92);
    chk(mem_m[93] == dv(11), "R8 upper word written back", mem_m[93], dv(11));
    // third victim: way 2 (line at 120), both halves dirty
    w0 = wcnt;
    op(1'b0, 1'b0, 248, '0);
    chk(lat == 19, "R8 two-half write-back latency", 32'(lat), 19);
    chk(wcnt == w0 + 8, "R8 eight beats", 32'(wcnt - w0), 8);
    chk(wlog[w0] == 120 && wlog[w0 + 7] == 127, "R8 lower half first", 32'(wlog[w0]), 120);
    chk(mem_m[122] == dv(12) && mem_m[126] == dv(14), "R8 both halves stored", mem_m[126], dv(14));
  endtask

  task automatic t_random;
    int w0, a, t;
    for (int k = 1; k <= 4; k++) op(1'b1, 1'b0, k * 32 + 8, dv(20 + k));
    cfg_rand = 1'b1;
    w0 = wcnt;
    op(1'b0, 1'b0, 168, '0);
    chk(lat == 15 && wcnt == w0 + 4, "R9 random victim write-back", 32'(wcnt - w0), 4);
    a = wlog[w0];
    t = a / 32;
    chk((a % 32) == 8 && t >= 1 && t <= 4, "R9 random victim within set", 32'(a), 32'(8));
    if (t >= 1 && t <= 4)
      chk(mem_m[10'(a)] == dv(20 + t), "R9 random victim data", mem_m[10'(a)], dv(20 + t));
    chk(rd == mval(168), "R9 data after random eviction", rd, mval(168));
  endtask

  task automatic t_invalidate;
    int r0, w0;
    @(negedge clk);
    inv_all = 1'b1; cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'd34;
    @(negedge clk);
    inv_all = 1'b0; cpu_req = 1'b0;
    chk(cpu_ready == 1'b1, "R10 request ignored during invalidate", 32'(cpu_ready), 1);
    @(negedge clk);
    chk(cpu_done == 1'b0, "R10 no completion for ignored request", 32'(cpu_done), 0);
    r0 = rd_cnt; w0 = wcnt;
    op(1'b0, 1'b0, 102, '0);
    chk(lat == 11, "R10 line invalid, no write-back", 32'(lat), 11);
    chk(wcnt == w0, "R10 dirty data discarded", 32'(wcnt - w0), 0);
    chk(rd == mval(102), "R10 data from memory", rd, mval(102));
    chk(rd_cnt == r0 + 1, "R10 refill issued", 32'(rd_cnt - r0), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_miss();
    t_read_hit();
    t_wt_hit();
    t_wt_miss();
    t_wb_store();
    t_round_robin();
    t_random();
    t_invalidate();
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule